// File: doc/BRIEF.md
# Set Lookup with Counter-Based Replacement

This block holds the tag state of one set of an N-way set-associative cache bank and makes every per-set decision that a lookup needs. Each way keeps a valid flag, a dirty flag, a tag and an age counter. A lookup presents a tag and a write flag. In the same cycle the block reports hit or miss, the hit way and the replacement way. It also states whether the request must be forwarded to memory, whether a line fill must be started, and whether a dirty victim must first be written back. The age counters and the dirty flags take their new values at the clock edge that closes the lookup.

Two write policies are chosen per request with one input. In write-back mode a write hit marks the line dirty, and a miss that evicts a dirty line asks for a writeback. In write-through mode every write goes to memory, and a write miss does not allocate a line. Line fills come back on a separate input that names the way to install and the tag. Memory line addresses are rebuilt by joining the tag with this set's index and this bank's index, which are fixed by parameters.

The surrounding pipeline owns request ordering, the miss tracking and the memory port. This block only produces the decisions and the addresses.

Top module: `set_lookup_lru`

## Requirements
- R1: After reset every way is invalid and clean with age zero, so the first lookup misses, reports victim way WAYS-1, requests a fill and requests no writeback.
- R2: A lookup whose tag equals the tag of a valid way raises `hit` and reports that way's index on `hit_way`, and that way's age becomes zero.
- R3: On every lookup, each valid way whose tag differs has its age incremented by one, saturating at 2^AGE_W-1. Invalid ways keep their age.
- R4: When all ways are valid, the victim is the way with the strictly largest age after the lookup's update. Scanning runs from way 0, so on a tie the lowest index wins. If no age exceeds zero, way 0 is the victim.
- R5: If any way is invalid, the victim is an invalid way, and among several invalid ways the highest index is chosen.
- R6: A write hit in write-back mode (`wr_through`=0) sets the hit way's dirty flag and forwards nothing to memory.
- R7: A write hit in write-through mode (`wr_through`=1) raises `fwd_req` with `line_addr` = {req_tag, SET_IDX, BANK_IDX} and does not set the dirty flag.
- R8: A miss in write-back mode with no invalid way, whose victim is dirty, raises `wb_req` with `wb_addr` = {victim tag, SET_IDX, BANK_IDX}. A clean victim gives no writeback.
- R9: A write miss in write-through mode raises `fwd_req` with `line_addr` and does not raise `fill_req`.
- R10: Every other miss raises `fill_req`. The fill goes to `victim_way` and is addressed by `line_addr`.
- R11: A fill (`fill_valid`=1) makes way `fill_way` valid with `fill_tag`, clean, and with age zero.
- R12: With `req_valid`=0, `hit`, `fill_req`, `fwd_req` and `wb_req` are all low, and no age or dirty flag changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_through | input | 1 | 1 selects write-through, 0 selects write-back for the current request |
| req_valid | input | 1 | Lookup present this cycle |
| req_write | input | 1 | Lookup is a write |
| req_tag | input | TAG_W | Lookup tag |
| fill_valid | input | 1 | Install a returned line this cycle |
| fill_way | input | WAY_W | Way to install |
| fill_tag | input | TAG_W | Tag of the installed line |
| hit | output | 1 | Lookup hit |
| hit_way | output | WAY_W | Index of the hit way |
| victim_way | output | WAY_W | Replacement way chosen for this lookup |
| fill_req | output | 1 | Miss needs a line fill into `victim_way` |
| fwd_req | output | 1 | Write must be forwarded to memory |
| line_addr | output | TAG_W+SET_BITS+BANK_BITS | Line address of the request |
| wb_req | output | 1 | Dirty victim must be written back |
| wb_addr | output | TAG_W+SET_BITS+BANK_BITS | Line address of the victim |

## Verification
A fixed opening sequence fills an empty set one way at a time, which shows whether the highest invalid way is picked over an age-based choice. It then drives repeated hits on a single way until the other three counters reach the ceiling, which separates saturation from wrap-around and tie-break-low from tie-break-high. A dirty line is aged into the victim slot to show the writeback address carries the victim's tag, not the request's. A long pseudo-random run over eight tags on four ways follows, first in write-back mode, then in write-through mode, then with the mode changing per request, with idle cycles and skipped fills mixed in. It is compared each cycle against an arithmetic model of the ages. This distinguishes correct increment, clearing and victim rules from near misses that only fail on particular age patterns, and it checks that dirty state left by write-back traffic is never written back under write-through.

// File: rtl/set_lru_pkg.sv
package set_lru_pkg;

    // What one lookup resolves to
    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_RD_HIT,
        ACT_WR_HIT_MARK,
        ACT_WR_HIT_FWD,
        ACT_WR_MISS_FWD,
        ACT_MISS_FILL
    } act_e;

    // Decision flags driven out of the set
    typedef struct packed {
        logic hit;
        logic mark_dirty;
        logic fwd_write;
        logic need_fill;
        logic write_back;
    } dec_t;

    function automatic act_e classify(logic vld, logic hit, logic wr, logic wt);
        if (!vld)
            return ACT_IDLE;
        if (hit) begin
            if (!wr)
                return ACT_RD_HIT;
            return wt ? ACT_WR_HIT_FWD : ACT_WR_HIT_MARK;
        end
        if (wr && wt)
            return ACT_WR_MISS_FWD;
        return ACT_MISS_FILL;
    endfunction

    function automatic dec_t decode(act_e a, logic evict_dirty);
        dec_t d;
        d = '0;
        case (a)
            ACT_RD_HIT: d.hit = 1'b1;
            ACT_WR_HIT_MARK: begin
                d.hit        = 1'b1;
                d.mark_dirty = 1'b1;
            end
            ACT_WR_HIT_FWD: begin
                d.hit       = 1'b1;
                d.fwd_write = 1'b1;
            end
            ACT_WR_MISS_FWD: d.fwd_write = 1'b1;
            ACT_MISS_FILL: begin
                d.need_fill  = 1'b1;
                d.write_back = evict_dirty;
            end
            default: d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/set_lru_way.sv
module set_lru_way #(
    parameter int TAG_W = 20,
    parameter int AGE_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [TAG_W-1:0] req_tag,
    input  logic             mark_dirty,
    input  logic             fill_en,
    input  logic [TAG_W-1:0] fill_tag,
    output logic             match,
    output logic             valid,
    output logic             dirty,
    output logic [TAG_W-1:0] tag,
    output logic [AGE_W-1:0] age_next
);

    localparam logic [AGE_W-1:0] AGE_MAX = '1;

    logic [AGE_W-1:0] age_q;
    logic             tag_eq;

    assign tag_eq = (tag == req_tag);
    assign match  = req_valid && valid && tag_eq;

    // Age after this lookup: clear on match, saturating step otherwise
    always_comb begin
        age_next = age_q;
        if (req_valid && valid) begin
            if (tag_eq)
                age_next = '0;
            else if (age_q != AGE_MAX)
                age_next = age_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            dirty <= 1'b0;
            tag   <= '0;
            age_q <= '0;
        end else if (fill_en) begin
            valid <= 1'b1;
            dirty <= 1'b0;
            tag   <= fill_tag;
            age_q <= '0;
        end else begin
            age_q <= age_next;
            if (mark_dirty)
                dirty <= 1'b1;
        end
    end

    // R11: an installed line is valid, clean, fresh, with the given tag
    a_r11_fill_installs: assert property (@(posedge clk) disable iff (rst)
        fill_en |=> valid && !dirty && (age_q == '0) && (tag == $past(fill_tag)));

    // R3: a non-matching valid way never loses age (no wrap)
    a_r3_no_wrap: assert property (@(posedge clk) disable iff (rst)
        req_valid && valid && !tag_eq && !fill_en |=> age_q >= $past(age_q));

    // R12: without a lookup or a fill the age is held
    a_r12_age_held: assert property (@(posedge clk) disable iff (rst)
        !req_valid && !fill_en |=> $stable(age_q) && $stable(dirty));

endmodule

// File: rtl/set_lru_victim.sv
module set_lru_victim #(
    parameter int WAYS  = 4,
    parameter int AGE_W = 4,
    parameter int WAY_W = 2
) (
    input  logic [WAYS-1:0]       valid,
    input  logic [WAYS*AGE_W-1:0] ages,
    output logic [WAY_W-1:0]      victim,
    output logic                  has_free
);

    logic [WAY_W-1:0] aged_pick;
    logic [WAY_W-1:0] free_pick;
    logic [AGE_W-1:0] best_age;

    // Oldest valid way; strict compare keeps the lowest index on ties
    always_comb begin
        aged_pick = '0;
        best_age  = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (valid[i] && (ages[i*AGE_W +: AGE_W] > best_age)) begin
                best_age  = ages[i*AGE_W +: AGE_W];
                aged_pick = WAY_W'(i);
            end
        end
    end

    // Highest-index invalid way
    always_comb begin
        free_pick = '0;
        has_free  = 1'b0;
        for (int i = 0; i < WAYS; i++) begin
            if (!valid[i]) begin
                free_pick = WAY_W'(i);
                has_free  = 1'b1;
            end
        end
    end

    assign victim = has_free ? free_pick : aged_pick;

endmodule

// File: rtl/set_lookup_lru.sv
module set_lookup_lru
    import set_lru_pkg::*;
#(
    parameter int WAYS      = 4,
    parameter int TAG_W     = 20,
    parameter int AGE_W     = 4,
    parameter int SET_BITS  = 6,
    parameter int BANK_BITS = 2,
    parameter int SET_IDX   = 0,
    parameter int BANK_IDX  = 0,
    localparam int WAY_W    = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int ADDR_W   = TAG_W + SET_BITS + BANK_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_through,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic              fill_valid,
    input  logic [WAY_W-1:0]  fill_way,
    input  logic [TAG_W-1:0]  fill_tag,
    output logic              hit,
    output logic [WAY_W-1:0]  hit_way,
    output logic [WAY_W-1:0]  victim_way,
    output logic              fill_req,
    output logic              fwd_req,
    output logic [ADDR_W-1:0] line_addr,
    output logic              wb_req,
    output logic [ADDR_W-1:0] wb_addr
);

    localparam logic [SET_BITS-1:0]  SET_VAL  = SET_BITS'(SET_IDX);
    localparam logic [BANK_BITS-1:0] BANK_VAL = BANK_BITS'(BANK_IDX);

    logic [WAYS-1:0]       match_v;
    logic [WAYS-1:0]       valid_v;
    logic [WAYS-1:0]       dirty_v;
    logic [TAG_W-1:0]      tag_a [WAYS];
    logic [WAYS*AGE_W-1:0] age_next_flat;
    logic                  has_free;
    logic                  evict_dirty;
    act_e                  act;
    dec_t                  dec;

    generate
        for (genvar g = 0; g < WAYS; g++) begin : g_way
            set_lru_way #(
                .TAG_W(TAG_W),
                .AGE_W(AGE_W)
            ) u_way (
                .clk       (clk),
                .rst       (rst),
                .req_valid (req_valid),
                .req_tag   (req_tag),
                .mark_dirty(dec.mark_dirty && match_v[g]),
                .fill_en   (fill_valid && (fill_way == WAY_W'(g))),
                .fill_tag  (fill_tag),
                .match     (match_v[g]),
                .valid     (valid_v[g]),
                .dirty     (dirty_v[g]),
                .tag       (tag_a[g]),
                .age_next  (age_next_flat[g*AGE_W +: AGE_W])
            );
        end
    endgenerate

    set_lru_victim #(
        .WAYS (WAYS),
        .AGE_W(AGE_W),
        .WAY_W(WAY_W)
    ) u_victim (
        .valid   (valid_v),
        .ages    (age_next_flat),
        .victim  (victim_way),
        .has_free(has_free)
    );

    always_comb begin
        hit_way = '0;
        for (int i = 0; i < WAYS; i++)
            if (match_v[i])
                hit_way = WAY_W'(i);
    end

    assign evict_dirty = !wr_through && !has_free && dirty_v[victim_way];
    assign act         = classify(req_valid, |match_v, req_write, wr_through);
    assign dec         = decode(act, evict_dirty);

    assign hit       = dec.hit;
    assign fill_req  = dec.need_fill;
    assign fwd_req   = dec.fwd_write;
    assign wb_req    = dec.write_back;
    assign line_addr = {req_tag, SET_VAL, BANK_VAL};
    assign wb_addr   = {tag_a[victim_way], SET_VAL, BANK_VAL};

    // R2: at most one way may match a tag
    a_r2_single_match: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match_v));

    // R12: no request, no action
    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> !(hit || fill_req || fwd_req || wb_req));

    // R9: write-through write miss goes to memory without allocation
    a_r9_wt_write_miss: assert property (@(posedge clk) disable iff (rst)
        req_valid && wr_through && req_write && !hit |-> fwd_req && !fill_req);

    // R8: writebacks only when the set is full and in write-back mode
    a_r8_wb_full_set: assert property (@(posedge clk) disable iff (rst)
        wb_req |-> (&valid_v) && !wr_through && !hit && fill_req);

    // R5: a free way is always preferred
    a_r5_free_victim: assert property (@(posedge clk) disable iff (rst)
        !(&valid_v) |-> !valid_v[victim_way]);

    // R6: a write-back write hit leaves the line dirty
    a_r6_mark_dirty: assert property (@(posedge clk) disable iff (rst)
        req_valid && !wr_through && req_write && hit && !fill_valid
        |=> dirty_v[$past(hit_way)]);

endmodule

// File: tb/sim_set_lookup_lru.sv
`timescale 1ns/1ps
module sim_set_lookup_lru;

    localparam int WAYS = 4, TAG_W = 4, AGE_W = 3, SET_BITS = 3, BANK_BITS = 2;
    localparam int SET_IDX = 5, BANK_IDX = 2;
    localparam int AMAX = 7;
    localparam int ADDR_W = TAG_W + SET_BITS + BANK_BITS;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_through = 1'b0, req_valid = 1'b0, req_write = 1'b0;
    logic [TAG_W-1:0] req_tag = '0, fill_tag = '0;
    logic fill_valid = 1'b0;
    logic [1:0] fill_way = '0;
    logic hit, fill_req, fwd_req, wb_req;
    logic [1:0] hit_way, victim_way;
    logic [ADDR_W-1:0] line_addr, wb_addr;

    always #2 clk = ~clk;

    set_lookup_lru #(
        .WAYS(WAYS), .TAG_W(TAG_W), .AGE_W(AGE_W), .SET_BITS(SET_BITS),
        .BANK_BITS(BANK_BITS), .SET_IDX(SET_IDX), .BANK_IDX(BANK_IDX)
    ) u0 (
        .clk(clk), .rst(rst), .wr_through(wr_through), .req_valid(req_valid),
        .req_write(req_write), .req_tag(req_tag), .fill_valid(fill_valid),
        .fill_way(fill_way), .fill_tag(fill_tag), .hit(hit), .hit_way(hit_way),
        .victim_way(victim_way), .fill_req(fill_req), .fwd_req(fwd_req),
        .line_addr(line_addr), .wb_req(wb_req), .wb_addr(wb_addr)
    );

    int n_chk = 0, n_bad = 0;
    bit m_valid [WAYS];
    bit m_dirty [WAYS];
    int m_tag [WAYS];
    int m_age [WAYS];

    function automatic int addr_of(int t);
        return (t << (SET_BITS + BANK_BITS)) | (SET_IDX << BANK_BITS) | BANK_IDX;
    endfunction

    task automatic chk(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic quiet_checks(input string what);
        chk({what, " hit"}, int'(hit), 0);
        chk({what, " fill_req"}, int'(fill_req), 0);
        chk({what, " fwd_req"}, int'(fwd_req), 0);
        chk({what, " wb_req"}, int'(wb_req), 0);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0; fill_valid = 1'b0;
        #1;
        quiet_checks("R12 idle");
    endtask

    task automatic fill(input int w, input int t);
        @(negedge clk);
        req_valid = 1'b0; fill_valid = 1'b1;
        fill_way = 2'(w); fill_tag = 4'(t);
        #1;
        quiet_checks("R12 fill cycle");
        m_valid[w] = 1'b1; m_dirty[w] = 1'b0; m_tag[w] = t; m_age[w] = 0;
    endtask

    task automatic lookup(input bit wr, input bit wt, input int t,
                          output bit nf, output int vw);
        int nage [WAYS];
        bit eh, free, efill, ewb;
        int ew, best, bage;
        @(negedge clk);
        fill_valid = 1'b0; req_valid = 1'b1; req_write = wr;
        wr_through = wt; req_tag = 4'(t);
        #1;
        eh = 1'b0; ew = 0;
        for (int i = 0; i < WAYS; i++) begin
            nage[i] = m_age[i];
            if (m_valid[i] && m_tag[i] == t) begin
                eh = 1'b1; ew = i; nage[i] = 0;
            end else if (m_valid[i] && m_age[i] < AMAX) begin
                nage[i] = m_age[i] + 1;
            end
        end
        best = 0; bage = 0;
        for (int i = 0; i < WAYS; i++)
            if (m_valid[i] && nage[i] > bage) begin
                bage = nage[i]; best = i;
            end
        free = 1'b0;
        for (int i = 0; i < WAYS; i++)
            if (!m_valid[i]) begin
                free = 1'b1; best = i;
            end
        efill = !eh && !(wr && wt);
        ewb   = efill && !wt && !free && m_dirty[best];
        chk("R2/R11 hit", int'(hit), int'(eh));
        if (eh) chk("R2 hit_way", int'(hit_way), ew);
        chk("R3/R4/R5 victim_way", int'(victim_way), best);
        chk("R10 fill_req", int'(fill_req), int'(efill));
        chk("R7/R9 fwd_req", int'(fwd_req), int'(wr && wt));
        if (efill || (wr && wt)) chk("R7/R10 line_addr", int'(line_addr), addr_of(t));
        chk("R6/R8 wb_req", int'(wb_req), int'(ewb));
        if (ewb) chk("R8 wb_addr", int'(wb_addr), addr_of(m_tag[best]));
        if (eh && wr && !wt) m_dirty[ew] = 1'b1;
        for (int i = 0; i < WAYS; i++) m_age[i] = nage[i];
        nf = efill; vw = best;
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        bit nf;
        int vw;
        logic [15:0] lfsr;
        for (int i = 0; i < WAYS; i++) begin
            m_valid[i] = 0; m_dirty[i] = 0; m_tag[i] = 0; m_age[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle();

        // R1: empty set
        lookup(0, 0, 1, nf, vw);
        chk("R1 first victim", int'(victim_way), 3);
        chk("R1 first fill_req", int'(fill_req), 1);
        chk("R1 no writeback", int'(wb_req), 0);
        fill(3, 1);
        // R5: highest free way next
        lookup(0, 0, 2, nf, vw);
        chk("R5 free victim", int'(victim_way), 2);
        fill(2, 2);
        lookup(0, 0, 3, nf, vw); fill(vw, 3);
        lookup(0, 0, 4, nf, vw); fill(vw, 4);

        // R6 then R8: dirty way 0 aged out
        lookup(1, 0, 4, nf, vw);
        chk("R6 no forward on write-back hit", int'(fwd_req), 0);
        for (int r = 0; r < 8; r++) begin
            lookup(0, 0, 1, nf, vw);
            lookup(0, 0, 2, nf, vw);
            lookup(0, 0, 3, nf, vw);
        end
        lookup(0, 0, 9, nf, vw);
        chk("R8 dirty victim way", int'(victim_way), 0);
        chk("R8 writeback raised", int'(wb_req), 1);
        chk("R8 writeback addr", int'(wb_addr), addr_of(4));
        fill(vw, 9);

        // R7 / R9 write-through
        lookup(1, 1, 9, nf, vw);
        chk("R7 forward on hit", int'(fwd_req), 1);
        chk("R7 forward addr", int'(line_addr), addr_of(9));
        lookup(1, 1, 14, nf, vw);
        chk("R9 forward on miss", int'(fwd_req), 1);
        chk("R9 no fill", int'(fill_req), 0);

        // R3 saturation and R4 tie-break
        for (int r = 0; r < 12; r++) lookup(0, 0, 9, nf, vw);
        lookup(0, 0, 13, nf, vw);
        chk("R3/R4 saturated tie victim", int'(victim_way), 1);
        chk("R11 refilled way clean", int'(wb_req), 0);
        fill(vw, 13);

        // pseudo-random sweep
        lfsr = 16'hACE1;
        for (int it = 0; it < 4500; it++) begin
            bit wt;
            int t;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            wt = (it < 1500) ? 1'b0 : ((it < 3000) ? 1'b1 : lfsr[9]);
            t = int'(lfsr[2:0]);
            if (lfsr[5:4] == 2'b00) begin
                idle();
            end else begin
                lookup(lfsr[3], wt, t, nf, vw);
                if (nf && lfsr[8:6] != 3'b000) fill(vw, t);
            end
        end
        @(negedge clk);
        req_valid = 1'b0; fill_valid = 1'b0;
        finish_run();
    end

endmodule